// File: doc/BRIEF.md
# Four-Context Dual-Issue Thread Scheduler

This block chooses, on every clock, which of a core's four hardware execution contexts feed its two issue slots. Each context sits in one of four states: idle, runnable, stalled on memory or done. Only runnable contexts compete for issue. A rotating pointer picks the first runnable context for slot 0. Slot 1 goes to the next runnable context in circular order. If there is no other runnable context, slot 1 goes to the slot 0 context again, but only when that context reports that its next two instructions are independent. The pointer then moves one past the last context granted. A context that issues a load drops out until its memory data returns. A context that issues its final instruction leaves for good.

Fetch and decode sit beside the block. They present, per context, a launch pulse, flags describing the next instruction (load, final, dual-issuable) and memory-return pulses. They read back the two slot grants and the packed context states. An idle-cycle counter records the clocks on which nothing could issue.

Top module: `issue_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every context reads idle, the idle counter reads 0 and both slot valids are low. State codes: 0 idle, 1 runnable, 2 stalled, 3 done. Context i occupies `ctx_state[2i+1:2i]`, and bit i of each per-context input belongs to context i.
- R2: An idle context with its `launch` bit set becomes runnable on the next clock. `launch` has no effect on a context in any other state.
- R3: A slot is granted only to a runnable context, and `slot1_vld` is never high while `slot0_vld` is low.
- R4: Slot 0 takes the first runnable context at or after the rotation pointer, in increasing index with wrap. Slot 1 takes the next runnable context after slot 0 in the same circular order. The pointer, which is 0 after reset, then moves to one past the last context granted, and holds when nothing is granted.
- R5: When the slot 0 context is the only runnable one and its `dual_ok` bit is set, slot 1 is granted to the same context. If another context is runnable, that other context takes slot 1 whatever `dual_ok` says.
- R6: A granted context whose `ld_req` bit is set (and `fin_req` clear) is stalled from the next clock. `ld_req` on a context that is not granted has no effect.
- R7: A stalled context whose `mem_ret` bit pulses is runnable from the next clock. `mem_ret` has no effect in other states.
- R8: A granted context whose `fin_req` bit is set is done from the next clock, even if `ld_req` is also set. A done context never changes state again and is never granted.
- R9: On a clock with no grant, the idle counter increments by one and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| launch | input | NCTX | Start an idle context |
| ld_req | input | NCTX | The context's next instruction is a memory load |
| fin_req | input | NCTX | The context's next instruction is its final one |
| dual_ok | input | NCTX | The context's next two instructions are independent |
| mem_ret | input | NCTX | Memory data returned for the context |
| slot0_vld | output | 1 | Slot 0 grant valid |
| slot0_ctx | output | IW | Context index in slot 0 |
| slot1_vld | output | 1 | Slot 1 grant valid |
| slot1_ctx | output | IW | Context index in slot 1 |
| ctx_state | output | 2*NCTX | Packed 2-bit state per context |
| idle_cnt | output | CNT_W | Count of clocks with no grant |

## Verification
The slot grants are combinational. They follow the registered context states, the rotation pointer and the same-cycle `dual_ok` flags, so they are due in the very cycle the inputs are applied. State changes and the idle count land one clock later. The bench drives each vector just after a falling edge and compares the grants about 1 ns later, before the next rising edge. It compares the state and count fields of a vector against what the previous vector's clock edge should have produced. Walking a continuous sequence this way exercises each one-cycle transition in turn. The rotation and wrap cases are checked in the same manner, and the counter wrap is checked after exactly 256 empty clocks.

// File: rtl/issue_sched_pkg.sv
`timescale 1ns/1ps
package issue_sched_pkg;

  typedef enum logic [1:0] {
    CTX_IDLE  = 2'd0,
    CTX_RUN   = 2'd1,
    CTX_STALL = 2'd2,
    CTX_DONE  = 2'd3
  } ctx_st_e;

  // Next state of one context; finishing outranks loading on a grant.
  function automatic ctx_st_e ctx_next(input ctx_st_e cur, input logic go,
                                       input logic gnt, input logic ld,
                                       input logic fin, input logic ret);
    ctx_st_e nx;
    nx = cur;
    case (cur)
      CTX_IDLE:  if (go) nx = CTX_RUN;
      CTX_RUN:   if (gnt) nx = fin ? CTX_DONE : (ld ? CTX_STALL : CTX_RUN);
      CTX_STALL: if (ret) nx = CTX_RUN;
      default:   nx = CTX_DONE;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/issue_ctx_fsm.sv
`timescale 1ns/1ps
module issue_ctx_fsm
  import issue_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    go,
  input  logic    gnt,
  input  logic    ld,
  input  logic    fin,
  input  logic    ret,
  output ctx_st_e st
);

  always_ff @(posedge clk) begin
    if (rst) st <= CTX_IDLE;
    else     st <= ctx_next(st, go, gnt, ld, fin, ret);
  end

endmodule

// File: rtl/issue_rr_pick.sv
`timescale 1ns/1ps
module issue_rr_pick #(
  parameter int NCTX = 4,
  localparam int IW = $clog2(NCTX)
) (
  input  logic [NCTX-1:0] elig,
  input  logic [NCTX-1:0] dual_ok,
  input  logic [IW-1:0]   ptr,
  output logic            s0_vld,
  output logic [IW-1:0]   s0_ctx,
  output logic            s1_vld,
  output logic [IW-1:0]   s1_ctx,
  output logic [IW-1:0]   ptr_nxt
);

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] i);
    return (i == IW'(NCTX - 1)) ? '0 : i + 1'b1;
  endfunction

  // First set bit of m at or after start, circularly; MSB flags a hit.
  function automatic logic [IW:0] scan(input logic [NCTX-1:0] m,
                                       input logic [IW-1:0] start);
    logic [IW:0] r;
    r = '0;
    for (int k = NCTX - 1; k >= 0; k--) begin
      int j;
      j = (int'(start) + k) % NCTX;
      if (m[j]) r = {1'b1, j[IW-1:0]};
    end
    return r;
  endfunction

  logic [IW:0]     hit_a, hit_b;
  logic [NCTX-1:0] rest;

  always_comb begin
    hit_a  = scan(elig, ptr);
    s0_vld = hit_a[IW];
    s0_ctx = s0_vld ? hit_a[IW-1:0] : '0;
    rest   = elig & ~(NCTX'(1) << s0_ctx);
    hit_b  = scan(rest, wrap_inc(s0_ctx));
    s1_vld = 1'b0;
    s1_ctx = '0;
    if (s0_vld && hit_b[IW]) begin
      s1_vld = 1'b1;
      s1_ctx = hit_b[IW-1:0];
    end else if (s0_vld && dual_ok[s0_ctx]) begin
      s1_vld = 1'b1;
      s1_ctx = s0_ctx;
    end
    if (s1_vld)      ptr_nxt = wrap_inc(s1_ctx);
    else if (s0_vld) ptr_nxt = wrap_inc(s0_ctx);
    else             ptr_nxt = ptr;
  end

endmodule

// File: rtl/issue_idle_ctr.sv
`timescale 1ns/1ps
module issue_idle_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/issue_sched.sv
`timescale 1ns/1ps
module issue_sched
  import issue_sched_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int CNT_W = 8,
  localparam int IW = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCTX-1:0]   launch,
  input  logic [NCTX-1:0]   ld_req,
  input  logic [NCTX-1:0]   fin_req,
  input  logic [NCTX-1:0]   dual_ok,
  input  logic [NCTX-1:0]   mem_ret,
  output logic              slot0_vld,
  output logic [IW-1:0]     slot0_ctx,
  output logic              slot1_vld,
  output logic [IW-1:0]     slot1_ctx,
  output logic [2*NCTX-1:0] ctx_state,
  output logic [CNT_W-1:0]  idle_cnt
);

  logic [IW-1:0]   rr_ptr, ptr_nxt;
  logic [NCTX-1:0] runnable;
  logic [NCTX-1:0] gnt_vec;    // contexts holding at least one slot
  logic            no_issue;   // nothing granted this clock
  ctx_st_e         st_q [NCTX];

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    assign gnt_vec[i] = (slot0_vld && slot0_ctx == IW'(i)) ||
                        (slot1_vld && slot1_ctx == IW'(i));
    issue_ctx_fsm u_fsm (
      .clk (clk),
      .rst (rst),
      .go  (launch[i]),
      .gnt (gnt_vec[i]),
      .ld  (ld_req[i]),
      .fin (fin_req[i]),
      .ret (mem_ret[i]),
      .st  (st_q[i])
    );
    assign runnable[i]          = (st_q[i] == CTX_RUN);
    assign ctx_state[2*i +: 2] = st_q[i];
  end

  issue_rr_pick #(.NCTX(NCTX)) u_pick (
    .elig    (runnable),
    .dual_ok (dual_ok),
    .ptr     (rr_ptr),
    .s0_vld  (slot0_vld),
    .s0_ctx  (slot0_ctx),
    .s1_vld  (slot1_vld),
    .s1_ctx  (slot1_ctx),
    .ptr_nxt (ptr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) rr_ptr <= '0;
    else     rr_ptr <= ptr_nxt;
  end

  assign no_issue = !slot0_vld;

  issue_idle_ctr #(.CNT_W(CNT_W)) u_idle (
    .clk  (clk),
    .rst  (rst),
    .tick (no_issue),
    .cnt  (idle_cnt)
  );

endmodule

// File: rtl/issue_sched_chk.sv
`timescale 1ns/1ps
module issue_sched_chk #(
  parameter int NCTX = 4,
  parameter int CNT_W = 8,
  localparam int IW = $clog2(NCTX)
) (
  input logic              clk,
  input logic              rst,
  input logic [NCTX-1:0]   launch,
  input logic [NCTX-1:0]   ld_req,
  input logic [NCTX-1:0]   fin_req,
  input logic [NCTX-1:0]   dual_ok,
  input logic [NCTX-1:0]   mem_ret,
  input logic              slot0_vld,
  input logic [IW-1:0]     slot0_ctx,
  input logic              slot1_vld,
  input logic [IW-1:0]     slot1_ctx,
  input logic [2*NCTX-1:0] ctx_state,
  input logic [CNT_W-1:0]  idle_cnt,
  input logic [NCTX-1:0]   gnt_vec,
  input logic              no_issue
);

  function automatic logic [1:0] st_of(input logic [2*NCTX-1:0] v,
                                       input logic [IW-1:0] i);
    return v[2*i +: 2];
  endfunction

  AST_SLOT1_NEEDS_SLOT0: assert property (@(posedge clk) disable iff (rst)
    slot1_vld |-> slot0_vld); // R3
  AST_SLOT0_RUNNABLE: assert property (@(posedge clk) disable iff (rst)
    slot0_vld |-> st_of(ctx_state, slot0_ctx) == 2'd1); // R3
  AST_SLOT1_RUNNABLE: assert property (@(posedge clk) disable iff (rst)
    slot1_vld |-> st_of(ctx_state, slot1_ctx) == 2'd1); // R3
  AST_DUAL_SAME_CTX: assert property (@(posedge clk) disable iff (rst)
    (slot1_vld && slot1_ctx == slot0_ctx) |-> dual_ok[slot0_ctx]); // R5
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    no_issue |=> idle_cnt == CNT_W'($past(idle_cnt) + 1'b1)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    slot0_vld |=> $stable(idle_cnt)); // R9

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx_chk
    AST_LAUNCH_RUN: assert property (@(posedge clk) disable iff (rst)
      (ctx_state[2*i +: 2] == 2'd0 && launch[i]) |=> ctx_state[2*i +: 2] == 2'd1); // R2
    AST_LOAD_STALL: assert property (@(posedge clk) disable iff (rst)
      (gnt_vec[i] && ld_req[i] && !fin_req[i]) |=> ctx_state[2*i +: 2] == 2'd2); // R6
    AST_RET_WAKE: assert property (@(posedge clk) disable iff (rst)
      (ctx_state[2*i +: 2] == 2'd2 && mem_ret[i]) |=> ctx_state[2*i +: 2] == 2'd1); // R7
    AST_FIN_DONE: assert property (@(posedge clk) disable iff (rst)
      (gnt_vec[i] && fin_req[i]) |=> ctx_state[2*i +: 2] == 2'd3); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      ctx_state[2*i +: 2] == 2'd3 |=> ctx_state[2*i +: 2] == 2'd3); // R8
  end

endmodule

bind issue_sched issue_sched_chk #(.NCTX(NCTX), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .launch    (launch),
  .ld_req    (ld_req),
  .fin_req   (fin_req),
  .dual_ok   (dual_ok),
  .mem_ret   (mem_ret),
  .slot0_vld (slot0_vld),
  .slot0_ctx (slot0_ctx),
  .slot1_vld (slot1_vld),
  .slot1_ctx (slot1_ctx),
  .ctx_state (ctx_state),
  .idle_cnt  (idle_cnt),
  .gnt_vec   (gnt_vec),
  .no_issue  (no_issue)
);

// File: tb/sim_issue_sched.sv
`timescale 1ns/1ps
module sim_issue_sched;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] launch = '0, ld_req = '0, fin_req = '0, dual_ok = '0, mem_ret = '0;
  logic       slot0_vld, slot1_vld;
  logic [1:0] slot0_ctx, slot1_ctx;
  logic [7:0] ctx_state;
  logic [7:0] idle_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  issue_sched #(.NCTX(4), .CNT_W(8)) u0 (
    .clk(clk), .rst(rst), .launch(launch), .ld_req(ld_req), .fin_req(fin_req),
    .dual_ok(dual_ok), .mem_ret(mem_ret), .slot0_vld(slot0_vld),
    .slot0_ctx(slot0_ctx), .slot1_vld(slot1_vld), .slot1_ctx(slot1_ctx),
    .ctx_state(ctx_state), .idle_cnt(idle_cnt)
  );

  // {launch, ld, fin, dual, ret, s0v, s0c, s1v, s1c, state c3..c0, idle}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {4'b1111,4'b0000,4'b0000,4'b0000,4'b0000, 1'b0,2'd0,1'b0,2'd0, 2'd0,2'd0,2'd0,2'd0, 8'd0}, // R1 R2
    {4'b0000,4'b0001,4'b0000,4'b0000,4'b0000, 1'b1,2'd0,1'b1,2'd1, 2'd1,2'd1,2'd1,2'd1, 8'd1}, // R4 R6
    {4'b0000,4'b0000,4'b1000,4'b0000,4'b0000, 1'b1,2'd2,1'b1,2'd3, 2'd1,2'd1,2'd1,2'd2, 8'd1}, // R8
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0001, 1'b1,2'd1,1'b1,2'd2, 2'd3,2'd1,2'd1,2'd2, 8'd1}, // R3 R7
    {4'b0000,4'b0110,4'b0000,4'b0000,4'b0000, 1'b1,2'd0,1'b1,2'd1, 2'd3,2'd1,2'd1,2'd1, 8'd1}, // R4 wrap
    {4'b0000,4'b0100,4'b0000,4'b0000,4'b0000, 1'b1,2'd2,1'b1,2'd0, 2'd3,2'd1,2'd2,2'd1, 8'd1}, // R6 ungranted ld
    {4'b1000,4'b0001,4'b0000,4'b0001,4'b0000, 1'b1,2'd0,1'b1,2'd0, 2'd3,2'd2,2'd2,2'd1, 8'd1}, // R5 R2
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0110, 1'b0,2'd0,1'b0,2'd0, 2'd3,2'd2,2'd2,2'd2, 8'd1}, // R9 R7
    {4'b0000,4'b0000,4'b0010,4'b0010,4'b0000, 1'b1,2'd1,1'b1,2'd2, 2'd3,2'd1,2'd1,2'd2, 8'd2}, // R5 other wins
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0010, 1'b1,2'd2,1'b0,2'd0, 2'd3,2'd1,2'd3,2'd2, 8'd2}, // R7 ret on done
    {4'b0000,4'b0000,4'b0000,4'b0100,4'b0001, 1'b1,2'd2,1'b1,2'd2, 2'd3,2'd1,2'd3,2'd2, 8'd2}, // R5
    {4'b0000,4'b0000,4'b0101,4'b0000,4'b0000, 1'b1,2'd0,1'b1,2'd2, 2'd3,2'd1,2'd3,2'd1, 8'd2}, // R4 R8
    {4'b1111,4'b0000,4'b0000,4'b0000,4'b0000, 1'b0,2'd0,1'b0,2'd0, 2'd3,2'd3,2'd3,2'd3, 8'd2}, // R8 R2
    {4'b0000,4'b0000,4'b0000,4'b0000,4'b0000, 1'b0,2'd0,1'b0,2'd0, 2'd3,2'd3,2'd3,2'd3, 8'd3}  // R8 R9
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_grant(input string tag, input bit v0, input int c0,
                             input bit v1, input int c1);
    check({tag, " slot0_vld"}, slot0_vld, v0);
    if (v0) check({tag, " slot0_ctx"}, slot0_ctx, c0);
    check({tag, " slot1_vld"}, slot1_vld, v1);
    if (v1) check({tag, " slot1_ctx"}, slot1_ctx, c1);
  endtask

  // Called just after a falling edge: apply, settle, compare, move on.
  task automatic step(input logic [3:0] la, input logic [3:0] ld,
                      input logic [3:0] fi, input logic [3:0] du,
                      input logic [3:0] mr);
    launch = la; ld_req = ld; fin_req = fi; dual_ok = du; mem_ret = mr;
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    launch = '0; ld_req = '0; fin_req = '0; dual_ok = '0; mem_ret = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    #1;
    check("R1 reset state", ctx_state, 0);
    check("R1 reset idle_cnt", idle_cnt, 0);
    check_grant("R1 reset grants", 0, 0, 0, 0);

    for (int v = 0; v < NV; v++) begin
      logic [41:0] e;
      e = VEC[v];
      step(e[41:38], e[37:34], e[33:30], e[29:26], e[25:22]);
      check_grant($sformatf("R4 R5 grant vec%0d", v), e[21], e[20:19], e[18], e[17:16]);
      check($sformatf("R2 R6 R7 R8 state vec%0d", v), ctx_state, e[15:8]);
      check($sformatf("R9 idle_cnt vec%0d", v), idle_cnt, e[7:0]);
      @(negedge clk);
    end

    // R4: steady rotation over four runnable contexts
    do_reset();
    step(4'b1111, 0, 0, 0, 0);
    @(negedge clk);
    step(0, 0, 0, 0, 0);
    check_grant("R4 rotate a", 1, 0, 1, 1);
    @(negedge clk);
    step(0, 0, 0, 0, 0);
    check_grant("R4 rotate b", 1, 2, 1, 3);
    @(negedge clk);
    step(0, 0, 0, 0, 0);
    check_grant("R4 rotate c", 1, 0, 1, 1);
    @(negedge clk);

    // R5 and R8: a lone context, then finish together with a load
    do_reset();
    step(4'b0100, 0, 0, 0, 0);
    @(negedge clk);
    step(0, 0, 0, 4'b0100, 0);
    check_grant("R5 lone dual", 1, 2, 1, 2);
    @(negedge clk);
    step(0, 4'b0100, 4'b0100, 4'b0000, 0);
    check_grant("R5 lone single", 1, 2, 0, 0);
    @(negedge clk);
    step(4'b0100, 0, 0, 0, 4'b0100);
    check("R8 fin beats ld", ctx_state[5:4], 3);
    check_grant("R8 done not granted", 0, 0, 0, 0);
    @(negedge clk);
    step(0, 0, 0, 0, 0);
    check("R8 done stays after launch/ret", ctx_state[5:4], 3);
    @(negedge clk);

    // R9: counter wraps after 256 empty clocks
    do_reset();
    step(0, 0, 0, 0, 0);
    repeat (256) @(negedge clk);
    #1;
    check("R9 idle_cnt wrap", idle_cnt, 0);
    @(negedge clk);
    #1;
    check("R9 idle_cnt after wrap", idle_cnt, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule